// File: doc/BRIEF.md
# Radix page table walker

The walker turns a 64-bit effective address into a physical address by reading an in-memory radix tree. When a request is accepted, it reads a partition-table doubleword to find the process table. It then reads the process-table entry to find the root directory and the tree size. After that it descends through directory entries until it reaches a leaf. Each directory level states its own index width, so the depth of the tree varies from one mapping to another. Every table access goes through a single 64-bit read port, and only one read is in flight at any time.

A request is accepted on `req_valid && req_ready`, and `req_ready` is high only while the walker is idle. The read port follows valid/ready rules. Once `mem_req_valid` rises, it stays high with a stable address until `mem_req_ready` is sampled high. The memory may hold off for any number of cycles. The response comes back on `mem_rsp_valid`, which has no back-pressure, and the walker ignores a response when no read is outstanding. The result appears on a one-cycle `done` pulse. At the same moment the walker presents the physical address and at most one error flag. These values hold until the next result.

All bit positions below count from the least significant bit (bit 0). A "bit k set" field means the value of that bit in the doubleword.

Top module: `radix_walker`

## Requirements
- R1: The first read goes to ((ptcr[59:12]) << 12) + 16·lpid + 8. The process table base is taken from that doubleword as (d[59:12] with its low d[4:0] bits cleared) << 12.
- R2: The process entry is read at process_base + 16·pid. Its root directory address is d[59:8] << 8, its root index width is d[4:0], and its tree size is RTS = {d[62:61], d[7:5]}, which spans RTS+31 address bits.
- R3: A segment error is reported when ea[63] differs from ea[62], or when any ea bit in 61..31 lies at or above position RTS+31. This check is made before any tree-size check.
- R4: A bad-tree error is reported when the root index width is below 5, above 16, or above RTS+19. In that case no directory is read.
- R5: A non-leaf directory entry whose index width d[4:0] is below 5, above 16, or above the remaining shift ends the walk with a bad-tree error.
- R6: Each level consumes the next index-width bits of the address below the previous level. The remaining shift becomes the old shift minus the width, and the next entry is read at (d[59:8] << 8) + 8·index, where index = (ea >> (12+shift)) masked to the width.
- R7: A directory entry with bit 63 (valid) clear ends the walk with a no-entry error.
- R8: For a valid leaf (bit 62 set), the physical address is (d & bits 56..12) OR (ea & (2^(12+shift) − 1)). The physical address reads zero whenever an error is reported.
- R9: A data access is allowed when leaf bit 1 (write) is set, or when bit 2 (read) is set and the access is not a store.
- R10: An instruction fetch is allowed only when leaf bit 0 (execute) is set and bit 5 (cache-inhibited half of the attribute field d[5:4]) is clear.
- R11: An unprivileged request to a leaf with bit 3 (privileged page) set gets a permission error. A privileged request is not affected by that bit.
- R12: The reference/change check needs bit 8 (R) set, and for a store also bit 7 (C). A reference/change error is reported only when the permission check passes, so at most one error flag is ever raised.
- R13: `req_ready` is high only when idle, and `done` is a single-cycle pulse. At most one memory read is outstanding, and a pending read request keeps its valid and address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptcr | input | 64 | Partition table control value, sampled at request acceptance |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_ea | input | 64 | Effective address |
| req_priv | input | 1 | Privileged access |
| req_store | input | 1 | Store access |
| req_iside | input | 1 | Instruction fetch |
| req_lpid | input | LPID_W | Partition index |
| req_pid | input | PID_W | Process index |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts read request |
| mem_req_addr | output | 64 | Table read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle result pulse |
| pa | output | 64 | Physical address |
| err_seg | output | 1 | Segment error |
| err_badtree | output | 1 | Bad tree configuration |
| err_noent | output | 1 | Invalid directory entry |
| err_perm | output | 1 | Permission error |
| err_rc | output | 1 | Reference/change error |

## Verification
A two-level tree is built in a behavioural memory whose request-ready toggles every cycle. A single leaf is then rewritten between runs. Loads, stores and fetches against different permission, attribute and R/C codes separate the read, write, execute, privilege and cache-inhibit rules, and they also show which of the permission and reference/change errors wins. Addresses with a high bit set, roots with a width that is too small or too large, an over-wide lower level and an empty slot each stop the walk at a different stage. A second partition whose table base has low bits set checks the alignment rule.

// File: rtl/radix_walker_pkg.sv
package radix_walker_pkg;
  localparam int AW        = 64;
  localparam int PG_SHIFT  = 12;
  localparam int SEG_LO    = 31;
  localparam int SEG_HI    = 61;
  localparam int LVL_MIN   = 5;
  localparam int LVL_MAX   = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PART,
    ST_PROC,
    ST_DIR
  } walk_state_e;

  typedef struct packed {
    logic seg;
    logic badtree;
    logic noent;
    logic perm;
    logic rc;
  } walk_err_t;
endpackage

// File: rtl/rw_level_calc.sv
module rw_level_calc
  import radix_walker_pkg::*;
(
  input  logic [AW-1:0] ea,
  input  logic [AW-1:0] entry,
  input  logic          is_root,
  input  logic [5:0]    shift_in,
  output logic          seg_err,
  output logic          bad_err,
  output logic [5:0]    shift_out,
  output logic [AW-1:0] next_addr
);
  logic [4:0]    tree_sz;
  logic [6:0]    tree_bits;
  logic [6:0]    avail;
  logic [6:0]    width;
  logic [AW-1:0] idx;
  logic          unused_lc;

  assign unused_lc = ^{entry[63], entry[60]};

  always_comb begin
    tree_sz   = {entry[62:61], entry[7:5]};
    tree_bits = 7'(tree_sz) + 7'(SEG_LO);
    seg_err   = 1'b0;
    if (is_root) begin
      if (ea[63] != ea[62]) seg_err = 1'b1;
      for (int k = SEG_LO; k <= SEG_HI; k++) begin
        if (ea[k] && (7'(k) >= tree_bits)) seg_err = 1'b1;
      end
    end
    avail     = is_root ? (7'(tree_sz) + 7'(SEG_LO - PG_SHIFT)) : 7'(shift_in);
    width     = 7'(entry[4:0]);
    bad_err   = (width < 7'(LVL_MIN)) || (width > 7'(LVL_MAX)) || (width > avail);
    shift_out = 6'(avail - width);
    idx       = (ea >> (7'(PG_SHIFT) + 7'(shift_out))) & ((64'd1 << width) - 64'd1);
    next_addr = {entry[59:8], 8'b0} + (idx << 3);
  end
endmodule

// File: rtl/rw_leaf_check.sv
module rw_leaf_check
  import radix_walker_pkg::*;
(
  input  logic [AW-1:0] entry,
  input  logic [AW-1:0] ea,
  input  logic [5:0]    shift,
  input  logic          priv,
  input  logic          store,
  input  logic          iside,
  output logic          perm_err,
  output logic          rc_err,
  output logic [AW-1:0] pa
);
  localparam logic [AW-1:0] RPN_MASK = 64'h01FF_FFFF_FFFF_F000;

  logic perm_ok;
  logic rc_ok;

  always_comb begin
    perm_ok = 1'b0;
    if (priv || !entry[3]) begin
      if (iside) perm_ok = entry[0] && !entry[5];
      else       perm_ok = entry[1] || (entry[2] && !store);
    end
    rc_ok    = entry[8] && (entry[7] || !store);
    perm_err = !perm_ok;
    rc_err   = perm_ok && !rc_ok;
    pa       = (entry & RPN_MASK) |
               (ea & ((64'd1 << (7'(PG_SHIFT) + 7'(shift))) - 64'd1));
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walker_pkg::*;
#(
  parameter int PID_W  = 20,
  parameter int LPID_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       ptcr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_ea,
  input  logic              req_priv,
  input  logic              req_store,
  input  logic              req_iside,
  input  logic [LPID_W-1:0] req_lpid,
  input  logic [PID_W-1:0]  req_pid,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              done,
  output logic [63:0]       pa,
  output logic              err_seg,
  output logic              err_badtree,
  output logic              err_noent,
  output logic              err_perm,
  output logic              err_rc
);
  walk_state_e     st;
  logic            pend;
  logic [AW-1:0]   ea_q;
  logic            priv_q, store_q, iside_q;
  logic [PID_W-1:0] pid_q;
  logic [5:0]      shift_q;
  logic [AW-1:0]   addr_q;
  walk_err_t       err_q;
  logic [AW-1:0]   pa_q;

  logic            lc_seg, lc_bad;
  logic [5:0]      lc_shift;
  logic [AW-1:0]   lc_next;
  logic            lf_perm, lf_rc;
  logic [AW-1:0]   lf_pa;

  logic            rsp_take;
  logic            fin, deeper;
  walk_err_t       fin_err;
  logic [AW-1:0]   fin_pa;
  logic [47:0]     prt_field;
  logic [AW-1:0]   prt_base;
  logic [AW-1:0]   part_addr;
  logic            unused_ptcr;

  assign unused_ptcr = ^{ptcr[63:60], ptcr[11:0]};

  rw_level_calc u_level (
    .ea        (ea_q),
    .entry     (mem_rsp_data),
    .is_root   (st == ST_PROC),
    .shift_in  (shift_q),
    .seg_err   (lc_seg),
    .bad_err   (lc_bad),
    .shift_out (lc_shift),
    .next_addr (lc_next)
  );

  rw_leaf_check u_leaf (
    .entry    (mem_rsp_data),
    .ea       (ea_q),
    .shift    (shift_q),
    .priv     (priv_q),
    .store    (store_q),
    .iside    (iside_q),
    .perm_err (lf_perm),
    .rc_err   (lf_rc),
    .pa       (lf_pa)
  );

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st != ST_IDLE) && !pend;
  assign mem_req_addr  = addr_q;
  assign rsp_take      = pend && mem_rsp_valid;

  assign prt_field = mem_rsp_data[59:12] & ~((48'd1 << mem_rsp_data[4:0]) - 48'd1);
  assign prt_base  = {4'b0, prt_field, 12'b0};
  assign part_addr = {4'b0, ptcr[59:12], 12'b0} + 64'({req_lpid, 4'b0}) + 64'd8;

  always_comb begin
    fin     = 1'b0;
    deeper  = 1'b0;
    fin_err = '0;
    fin_pa  = '0;
    if (rsp_take) begin
      case (st)
        ST_PROC: begin
          if (lc_seg)      begin fin = 1'b1; fin_err.seg = 1'b1; end
          else if (lc_bad) begin fin = 1'b1; fin_err.badtree = 1'b1; end
          else             deeper = 1'b1;
        end
        ST_DIR: begin
          if (!mem_rsp_data[63]) begin
            fin = 1'b1; fin_err.noent = 1'b1;
          end else if (mem_rsp_data[62]) begin
            fin          = 1'b1;
            fin_err.perm = lf_perm;
            fin_err.rc   = lf_rc;
            if (!lf_perm && !lf_rc) fin_pa = lf_pa;
          end else if (lc_bad) begin
            fin = 1'b1; fin_err.badtree = 1'b1;
          end else begin
            deeper = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pend    <= 1'b0;
      ea_q    <= '0;
      priv_q  <= 1'b0;
      store_q <= 1'b0;
      iside_q <= 1'b0;
      pid_q   <= '0;
      shift_q <= '0;
      addr_q  <= '0;
      err_q   <= '0;
      pa_q    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (req_valid) begin
          ea_q    <= req_ea;
          priv_q  <= req_priv;
          store_q <= req_store;
          iside_q <= req_iside;
          pid_q   <= req_pid;
          addr_q  <= part_addr;
          st      <= ST_PART;
        end
      end else begin
        if (mem_req_valid && mem_req_ready) pend <= 1'b1;
        if (rsp_take) pend <= 1'b0;
        if (rsp_take && st == ST_PART) begin
          addr_q <= prt_base + 64'({pid_q, 4'b0});
          st     <= ST_PROC;
        end
        if (fin) begin
          err_q <= fin_err;
          pa_q  <= fin_pa;
          done  <= 1'b1;
          st    <= ST_IDLE;
        end else if (deeper) begin
          addr_q  <= lc_next;
          shift_q <= lc_shift;
          st      <= ST_DIR;
        end
      end
    end
  end

  assign pa          = pa_q;
  assign err_seg     = err_q.seg;
  assign err_badtree = err_q.badtree;
  assign err_noent   = err_q.noent;
  assign err_perm    = err_q.perm;
  assign err_rc      = err_q.rc;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
  parameter int PID_W  = 20,
  parameter int LPID_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [63:0]       ptcr,
  input logic              req_valid,
  input logic              req_ready,
  input logic [63:0]       req_ea,
  input logic              req_priv,
  input logic              req_store,
  input logic              req_iside,
  input logic [LPID_W-1:0] req_lpid,
  input logic [PID_W-1:0]  req_pid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [63:0]       mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [63:0]       mem_rsp_data,
  input logic              done,
  input logic [63:0]       pa,
  input logic              err_seg,
  input logic              err_badtree,
  input logic              err_noent,
  input logic              err_perm,
  input logic              err_rc
);
  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst <= 1'b1;
    else if (mem_rsp_valid) outst <= 1'b0;
  end

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r13_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r13_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !mem_req_valid);

  a_r12_single_error: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({err_seg, err_badtree, err_noent, err_perm, err_rc}) <= 1);

  a_r8_pa_zero_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    done && (err_seg || err_badtree || err_noent || err_perm || err_rc) |-> pa == 64'd0);
endmodule

bind radix_walker radix_walker_chk #(.PID_W(PID_W), .LPID_W(LPID_W)) chk_i (.*);

// File: tb/radix_walker_tb_top.sv
module radix_walker_tb_top;
  localparam int PID_W  = 20;
  localparam int LPID_W = 12;
  localparam logic [4:0] E_OK  = 5'b00000;
  localparam logic [4:0] E_SEG = 5'b10000;
  localparam logic [4:0] E_BAD = 5'b01000;
  localparam logic [4:0] E_NOE = 5'b00100;
  localparam logic [4:0] E_PRM = 5'b00010;
  localparam logic [4:0] E_RC  = 5'b00001;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [63:0]       ptcr = 64'h10000;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [63:0]       req_ea = '0;
  logic              req_priv = 1'b0;
  logic              req_store = 1'b0;
  logic              req_iside = 1'b0;
  logic [LPID_W-1:0] req_lpid = '0;
  logic [PID_W-1:0]  req_pid = '0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [63:0]       mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [63:0]       mem_rsp_data = '0;
  logic              done;
  logic [63:0]       pa;
  logic              err_seg, err_badtree, err_noent, err_perm, err_rc;

  always #10 clk = ~clk;

  radix_walker #(.PID_W(PID_W), .LPID_W(LPID_W)) dut_i (.*);

  typedef struct {
    logic [4:0]  err;
    logic [63:0] pa;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [63:0] mem [logic [63:0]];
  int n_chk = 0;
  int n_fail = 0;
  logic prev_done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] leaf(input logic [3:0] perm, input logic r, input logic c, input logic [1:0] att);
    return 64'hC000_0000_8000_0000 | (64'(r) << 8) | (64'(c) << 7) | (64'(att) << 4) | 64'(perm);
  endfunction

  // memory model: request-ready toggles, response one cycle after acceptance
  initial begin
    forever begin
      @(posedge clk);
      mem_req_ready <= ~mem_req_ready;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        check(!prev_done, "R13 done pulse", 64'(prev_done), 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R13 unexpected result", 64'd1, 64'd0);
        end else begin
          e = exp_q.pop_front();
          check({err_seg, err_badtree, err_noent, err_perm, err_rc} == e.err,
                {e.tag, " flags"}, 64'({err_seg, err_badtree, err_noent, err_perm, err_rc}), 64'(e.err));
          check(pa == e.pa, {e.tag, " pa"}, pa, e.pa);
        end
      end
      prev_done = done;
    end
  end

  task automatic run(input logic [63:0] ea, input logic priv, input logic store, input logic iside,
                     input logic [LPID_W-1:0] lpid, input logic [PID_W-1:0] pid,
                     input logic [4:0] err, input logic [63:0] epa, input string tag);
    exp_t e;
    e.err = err; e.pa = epa; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_ea = ea; req_priv = priv; req_store = store; req_iside = iside;
    req_lpid = lpid; req_pid = pid; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R13 busy during walk", 64'(req_ready), 64'd0);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] ea_a, pa_a, leaf_at;
    ea_a    = 64'h000F_EDCB_A987_6543;
    pa_a    = 64'h8000_0000 | (ea_a & 64'h3FFF_FFFF);
    // tables
    mem[64'h10008] = 64'h20000;                       // lpid 0
    mem[64'h10018] = 64'h21001;                       // lpid 1, low base bit cleared by size 1
    mem[64'h20010] = 64'h4000_0000_0003_00AD;         // pid 1: size 21, root 0x30000, width 13
    mem[64'h20020] = 64'h4000_0000_0003_00A4;         // pid 2: width 4
    mem[64'h20030] = 64'h4000_0000_0003_00B1;         // pid 3: width 17
    mem[64'h20040] = 64'h50010;                       // pid 4: size 0, width 16
    mem[64'h50000] = 64'h8000_0000_0006_0005;         // width 5 over shift 3
    mem[64'h30000 + 8 * ((ea_a >> 39) & 64'h1FFF)] = 64'h8000_0000_0004_0009;
    leaf_at = 64'h40000 + 8 * ((ea_a >> 30) & 64'h1FF);

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R13 reset ready", 64'(req_ready), 64'd1);
    check(done == 1'b0, "R13 reset done", 64'(done), 64'd0);
    check(mem_req_valid == 1'b0, "R13 reset no read", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;

    mem[leaf_at] = leaf(4'b0110, 1, 0, 2'b00);
    run(ea_a, 0, 0, 0, 0, 1, E_OK,  pa_a, "R8 R6 R2 load translates");
    mem[leaf_at] = leaf(4'b0100, 1, 1, 2'b00);
    run(ea_a, 0, 1, 0, 0, 1, E_PRM, 0, "R9 store to read-only");
    mem[leaf_at] = leaf(4'b0010, 1, 0, 2'b00);
    run(ea_a, 0, 1, 0, 0, 1, E_RC,  0, "R12 store without C");
    mem[leaf_at] = leaf(4'b0010, 1, 1, 2'b00);
    run(ea_a, 0, 1, 0, 0, 1, E_OK,  pa_a, "R9 store with write");
    mem[leaf_at] = leaf(4'b0010, 1, 0, 2'b00);
    run(ea_a, 0, 0, 0, 0, 1, E_OK,  pa_a, "R9 load via write");
    mem[leaf_at] = leaf(4'b0000, 0, 0, 2'b00);
    run(ea_a, 0, 0, 0, 0, 1, E_PRM, 0, "R12 perm wins over R");
    mem[leaf_at] = leaf(4'b1110, 1, 1, 2'b00);
    run(ea_a, 0, 0, 0, 0, 1, E_PRM, 0, "R11 user on priv page");
    run(ea_a, 1, 0, 0, 0, 1, E_OK,  pa_a, "R11 priv on priv page");
    mem[leaf_at] = leaf(4'b0001, 1, 0, 2'b00);
    run(ea_a, 0, 0, 1, 0, 1, E_OK,  pa_a, "R10 fetch exec");
    mem[leaf_at] = leaf(4'b0001, 1, 0, 2'b01);
    run(ea_a, 0, 0, 1, 0, 1, E_OK,  pa_a, "R10 fetch att 01");
    mem[leaf_at] = leaf(4'b0001, 1, 0, 2'b10);
    run(ea_a, 0, 0, 1, 0, 1, E_PRM, 0, "R10 fetch inhibited");
    mem[leaf_at] = leaf(4'b0110, 1, 1, 2'b00);
    run(ea_a, 0, 0, 1, 0, 1, E_PRM, 0, "R10 fetch no exec");
    run(ea_a | (64'd1 << 63), 0, 0, 0, 0, 1, E_SEG, 0, "R3 top bits differ");
    run(ea_a | (64'd1 << 55), 0, 0, 0, 0, 1, E_SEG, 0, "R3 bit above tree");
    run(ea_a | (64'd1 << 63), 0, 0, 0, 0, 2, E_SEG, 0, "R3 seg before badtree");
    run(ea_a, 0, 0, 0, 0, 2, E_BAD, 0, "R4 root width 4");
    run(ea_a, 0, 0, 0, 0, 3, E_BAD, 0, "R4 root width 17");
    run(64'h1000, 0, 0, 0, 0, 4, E_BAD, 0, "R5 level over shift");
    run(ea_a ^ (64'd1 << 30), 0, 0, 0, 0, 1, E_NOE, 0, "R7 empty slot");
    run(ea_a, 0, 0, 0, 1, 1, E_OK,  pa_a, "R1 aligned process base");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R13 all results seen", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule